// File: doc/BRIEF.md
# Clock Control Register Bank

This block is a bank of clock-control registers on a word-addressed bus. Each access takes one cycle. The bank holds a mode word, two post-divider words, two PLL control words, three clock-gating words and a power-management word. Every register has its own reset value and its own write mask. Software programs the bank to choose the reference source, to bypass or use the main PLL, and to set the two post-dividers.

From the mode word, the first divider word and the main PLL word, the block derives four frequencies as 32-bit Hz values: the reference clock, the core clock, the high-speed clock and the peripheral clock. A write to a register that affects these values starts a multi-cycle recalculation. The recalculation runs on a shared serial divider. While it runs, the old frequencies stay on the outputs and the bus stalls. All four new values then appear together.

The request channel is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low for as long as `busy` is high, so the requester must hold its request steady until it is taken. Read data comes back one cycle after the read is taken, marked by a one-cycle `rsp_valid` pulse. The response channel cannot be stalled.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset these words read back: offset 0 = 0x074B0B7B, offset 1 = 0xFF870B48, offset 2 = 0x49FCFE7F, offset 4 = 0x04001800, offset 6 = 0x04043001, offsets 8/9/10 = 0xFFFFFFFF, offset 23 = 0x80209828.
- R2: A write to offset 0 stores (data & 0x3B6FDFFF) | (1 << 26), so bit 26 always reads back as 1.
- R3: A write to offset 1 stores data & 0xFF9F3FFF. Writes to offsets 4 and 6 store data & 0xBFFF3FFF. Writes to offsets 2 and 8..10 store all 32 bits.
- R4: Offset 18 always reads 0x00004040. Other unmapped offsets read 0. Writes to offset 18, to offset 23 and to unmapped offsets change no readable value and start no recalculation.
- R5: `rsp_valid` pulses one cycle after a read is taken, carrying that word. `req_ready` is low whenever `busy` is high.
- R6: The reference output is 33554432 Hz when mode bits [2:1] equal 2, and 26000000 Hz otherwise.
- R7: The core output equals the reference when mode bit 7 is set or mode bit 0 is clear. Otherwise it is the PLL output, computed from the main PLL word (MFN = bits [9:0], signed; MFI = bits [13:10], raised to a minimum of 5; MFD = bits [25:16]; PD = bits [29:26]) as ((2·(ref>>10)·(MFI·(MFD+1)+MFN)) / ((MFD+1)·(PD+1))) << 10, truncated to 32 bits, and 0 when the bracketed term is not positive.
- R8: The high-speed output is core / (1 + divider0 bits [13:11]). The peripheral output is high-speed / (1 + divider0 bits [7:6]). Both divisions truncate.
- R9: Writes to offsets 0, 1, 2, 4 and 6 raise `busy` in the following cycle. Writes to offsets 8..10 do not.
- R10: While `busy` is high, all four frequency outputs hold their previous values, and they change only when `busy` falls. After reset they read 0, and a recalculation with the reset values starts by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| busy | output | 1 | Frequency recalculation in progress |
| ref_hz | output | 32 | Reference clock, Hz |
| core_hz | output | 32 | Core clock, Hz |
| hs_hz | output | 32 | High-speed clock, Hz |
| per_hz | output | 32 | Peripheral clock, Hz |

## Verification
The checks on holding values and on back-pressure assume that the requester treats `req_ready` as binding. They also assume `req_valid` stays low during reset, so that no response can appear without a request behind it. The stimulus drives and releases each request on falling edges and waits for `req_ready` before it presents one. The PLL words the stimulus writes keep the numerator inside 32 bits, so that truncating it does not confuse the legality and ordering checks on the frequencies.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {FS_IDLE, FS_PLL, FS_HSP, FS_IPG} fstate_t;

  // word offsets
  localparam int unsigned OFF_MODE  = 0;
  localparam int unsigned OFF_DIV0  = 1;
  localparam int unsigned OFF_DIV1  = 2;
  localparam int unsigned OFF_PLLM  = 4;
  localparam int unsigned OFF_PLLS  = 6;
  localparam int unsigned OFF_GATE0 = 8;
  localparam int unsigned N_GATE    = 3;
  localparam int unsigned OFF_CONST = 18;
  localparam int unsigned OFF_PM    = 23;

  // reset values and write masks
  localparam logic [DW-1:0] RST_MODE  = 32'h074B_0B7B;
  localparam logic [DW-1:0] RST_DIV0  = 32'hFF87_0B48;
  localparam logic [DW-1:0] RST_DIV1  = 32'h49FC_FE7F;
  localparam logic [DW-1:0] RST_PLLM  = 32'h0400_1800;
  localparam logic [DW-1:0] RST_PLLS  = 32'h0404_3001;
  localparam logic [DW-1:0] RST_GATE  = 32'hFFFF_FFFF;
  localparam logic [DW-1:0] VAL_PM    = 32'h8020_9828;
  localparam logic [DW-1:0] VAL_CONST = 32'h0000_4040;
  localparam logic [DW-1:0] MSK_MODE  = 32'h3B6F_DFFF;
  localparam logic [DW-1:0] MSK_DIV0  = 32'hFF9F_3FFF;
  localparam logic [DW-1:0] MSK_PLL   = 32'hBFFF_3FFF;
  localparam int unsigned   FORCE_BIT = 26;

  // mode / divider field positions
  localparam int unsigned MODE_PLLEN  = 0;
  localparam int unsigned MODE_BYPASS = 7;
  localparam int unsigned MODE_SRC_LO = 1;

  // reference frequencies
  localparam logic [DW-1:0] REF_XTAL = 32'd26_000_000;
  localparam logic [DW-1:0] REF_LOW  = 32'd33_554_432;
endpackage

// File: rtl/clkctl_div.sv
module clkctl_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial;

  assign trial = {rem_q, q_q[W-1]};
  assign quo   = q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      q_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        q_q   <= num;
        d_q   <= den;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (trial >= {1'b0, d_q}) begin
          rem_q <= W'(trial - {1'b0, d_q});
          q_q   <= {q_q[W-2:0], 1'b1};
        end else begin
          rem_q <= trial[W-1:0];
          q_q   <= {q_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clkctl_pll_math.sv
module clkctl_pll_math (
  input  logic [31:0] ctl,
  input  logic [31:0] ref_hz,
  output logic [31:0] num,
  output logic [31:0] den,
  output logic        pos
);
  logic [9:0]         frac;
  logic [3:0]         whole_raw, whole;
  logic [10:0]        dplus;
  logic [4:0]         pplus;
  logic [14:0]        prod;
  logic signed [17:0] term;

  always_comb begin
    frac      = ctl[9:0];
    whole_raw = ctl[13:10];
    whole     = (whole_raw < 4'd5) ? 4'd5 : whole_raw;
    dplus     = {1'b0, ctl[25:16]} + 11'd1;
    pplus     = {1'b0, ctl[29:26]} + 5'd1;
    prod      = 15'(whole) * 15'(dplus);
    term      = $signed({3'b000, prod}) + $signed({{8{frac[9]}}, frac});
    pos       = !term[17] && (term != 18'sd0);
    num       = (32'(ref_hz >> 10) * 32'(term[16:0])) << 1;
    den       = 32'(dplus) * 32'(pplus);
  end
endmodule

// File: rtl/clkctl_freq_seq.sv
module clkctl_freq_seq
  import clkctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] mode,
  input  logic [DW-1:0] div0,
  input  logic [DW-1:0] pllm,
  output logic          busy,
  output logic [DW-1:0] ref_hz,
  output logic [DW-1:0] core_hz,
  output logic [DW-1:0] hs_hz,
  output logic [DW-1:0] per_hz
);
  fstate_t       st_q;
  logic [DW-1:0] core_t, hs_t, dnum_q, dden_q, pnum, pden, dquo, ref_sel;
  logic [DW-1:0] hs_div, per_div;
  logic          dstart_q, ddone, ppos, bypass;

  assign ref_sel = (mode[MODE_SRC_LO+1:MODE_SRC_LO] == 2'd2) ? REF_LOW : REF_XTAL;
  assign bypass  = mode[MODE_BYPASS] | ~mode[MODE_PLLEN];
  assign hs_div  = DW'(div0[13:11]) + 1'b1;
  assign per_div = DW'(div0[7:6]) + 1'b1;
  assign busy    = (st_q != FS_IDLE);

  clkctl_pll_math u_pll (.ctl(pllm), .ref_hz(ref_sel), .num(pnum), .den(pden), .pos(ppos));

  clkctl_div #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .start(dstart_q), .num(dnum_q), .den(dden_q),
    .done(ddone), .quo(dquo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= FS_IDLE;
      core_t   <= '0;
      hs_t     <= '0;
      dnum_q   <= '0;
      dden_q   <= '0;
      dstart_q <= 1'b0;
      ref_hz   <= '0;
      core_hz  <= '0;
      hs_hz    <= '0;
      per_hz   <= '0;
    end else begin
      dstart_q <= 1'b0;
      unique case (st_q)
        FS_IDLE: if (start) begin
          dstart_q <= 1'b1;
          if (bypass || !ppos) begin
            core_t <= bypass ? ref_sel : '0;
            dnum_q <= bypass ? ref_sel : '0;
            dden_q <= hs_div;
            st_q   <= FS_HSP;
          end else begin
            dnum_q <= pnum;
            dden_q <= pden;
            st_q   <= FS_PLL;
          end
        end
        FS_PLL: if (ddone) begin
          core_t   <= dquo << 10;
          dnum_q   <= dquo << 10;
          dden_q   <= hs_div;
          dstart_q <= 1'b1;
          st_q     <= FS_HSP;
        end
        FS_HSP: if (ddone) begin
          hs_t     <= dquo;
          dnum_q   <= dquo;
          dden_q   <= per_div;
          dstart_q <= 1'b1;
          st_q     <= FS_IPG;
        end
        FS_IPG: if (ddone) begin
          ref_hz  <= ref_sel;
          core_hz <= core_t;
          hs_hz   <= hs_t;
          per_hz  <= dquo;
          st_q    <= FS_IDLE;
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
  import clkctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              busy,
  output logic [DW-1:0]     ref_hz,
  output logic [DW-1:0]     core_hz,
  output logic [DW-1:0]     hs_hz,
  output logic [DW-1:0]     per_hz
);
  logic [DW-1:0] mode_q, div0_q, div1_q, pllm_q, plls_q, rd_mux;
  logic [DW-1:0] gate_q [N_GATE];
  logic          kick_q, seq_busy, acc, wr, wr_trig;

  assign acc       = req_valid & req_ready;
  assign wr        = acc & req_write;
  assign wr_trig   = wr & ((req_addr == ADDR_W'(OFF_MODE)) | (req_addr == ADDR_W'(OFF_DIV0)) |
                           (req_addr == ADDR_W'(OFF_DIV1)) | (req_addr == ADDR_W'(OFF_PLLM)) |
                           (req_addr == ADDR_W'(OFF_PLLS)));
  assign busy      = kick_q | seq_busy;
  assign req_ready = ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= RST_MODE;
      div0_q <= RST_DIV0;
      div1_q <= RST_DIV1;
      pllm_q <= RST_PLLM;
      plls_q <= RST_PLLS;
      kick_q <= 1'b1;
    end else begin
      kick_q <= wr_trig;
      if (wr) begin
        if (req_addr == ADDR_W'(OFF_MODE)) mode_q <= (req_wdata & MSK_MODE) | (DW'(1) << FORCE_BIT);
        if (req_addr == ADDR_W'(OFF_DIV0)) div0_q <= req_wdata & MSK_DIV0;
        if (req_addr == ADDR_W'(OFF_DIV1)) div1_q <= req_wdata;
        if (req_addr == ADDR_W'(OFF_PLLM)) pllm_q <= req_wdata & MSK_PLL;
        if (req_addr == ADDR_W'(OFF_PLLS)) plls_q <= req_wdata & MSK_PLL;
      end
    end
  end

  for (genvar g = 0; g < N_GATE; g++) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) gate_q[g] <= RST_GATE;
      else if (wr && req_addr == ADDR_W'(OFF_GATE0 + g)) gate_q[g] <= req_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == ADDR_W'(OFF_MODE))  rd_mux = mode_q;
    if (req_addr == ADDR_W'(OFF_DIV0))  rd_mux = div0_q;
    if (req_addr == ADDR_W'(OFF_DIV1))  rd_mux = div1_q;
    if (req_addr == ADDR_W'(OFF_PLLM))  rd_mux = pllm_q;
    if (req_addr == ADDR_W'(OFF_PLLS))  rd_mux = plls_q;
    if (req_addr == ADDR_W'(OFF_CONST)) rd_mux = VAL_CONST;
    if (req_addr == ADDR_W'(OFF_PM))    rd_mux = VAL_PM;
    for (int g = 0; g < N_GATE; g++)
      if (req_addr == ADDR_W'(OFF_GATE0 + g)) rd_mux = gate_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc & ~req_write;
      if (acc & ~req_write) rsp_rdata <= rd_mux;
    end
  end

  clkctl_freq_seq u_seq (
    .clk(clk), .rst(rst), .start(kick_q), .mode(mode_q), .div0(div0_q), .pllm(pllm_q),
    .busy(seq_busy), .ref_hz(ref_hz), .core_hz(core_hz), .hs_hz(hs_hz), .per_hz(per_hz)
  );
endmodule

// File: rtl/clkctl_regfile_chk.sv
module clkctl_regfile_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              busy,
  input logic [31:0]       ref_hz,
  input logic [31:0]       core_hz,
  input logic [31:0]       hs_hz,
  input logic [31:0]       per_hz
);
  logic rd_acc, gate_wr;
  assign rd_acc  = req_valid && req_ready && !req_write;
  assign gate_wr = req_valid && req_ready && req_write &&
                   (req_addr >= ADDR_W'(8)) && (req_addr <= ADDR_W'(10));

  a_r5_busy_backpressure: assert property (@(posedge clk) disable iff (rst)
    busy |-> !req_ready);

  a_r5_read_response: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rsp_valid);

  a_r5_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(rd_acc));

  a_r10_hold_core: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(core_hz) && $stable(hs_hz) && $stable(per_hz) && $stable(ref_hz)));

  a_r6_ref_legal: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (ref_hz == 32'd26000000 || ref_hz == 32'd33554432));

  a_r8_order: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (hs_hz <= core_hz && per_hz <= hs_hz));

  a_r9_gate_no_recalc: assert property (@(posedge clk) disable iff (rst)
    gate_wr |=> !busy);
endmodule

bind clkctl_regfile clkctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid), .busy(busy),
  .ref_hz(ref_hz), .core_hz(core_hz), .hs_hz(hs_hz), .per_hz(per_hz)
);

// File: tb/sim_clkctl_regfile.sv
`timescale 1ns/1ps
module sim_clkctl_regfile;
  localparam int unsigned AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, busy;
  logic [31:0]   rsp_rdata, ref_hz, core_hz, hs_hz, per_hz;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] sh_mode = 32'h074B0B7B, sh_div0 = 32'hFF870B48, sh_pllm = 32'h04001800;

  always #2 clk = ~clk;

  clkctl_regfile #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
    .ref_hz(ref_hz), .core_hz(core_hz), .hs_hz(hs_hz), .per_hz(per_hz)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // reference model written from R6..R8
  task automatic model(output logic [31:0] r, c, h, p);
    longint mfi, mfd1, pd1, mfn, term, raw;
    r = (sh_mode[2:1] == 2'd2) ? 32'd33554432 : 32'd26000000;
    mfi  = sh_pllm[13:10]; if (mfi < 5) mfi = 5;
    mfd1 = longint'(sh_pllm[25:16]) + 1;
    pd1  = longint'(sh_pllm[29:26]) + 1;
    mfn  = sh_pllm[9] ? longint'(sh_pllm[9:0]) - 1024 : longint'(sh_pllm[9:0]);
    term = mfi * mfd1 + mfn;
    if (sh_mode[7] || !sh_mode[0]) c = r;
    else if (term <= 0) c = 0;
    else begin
      raw = (2 * longint'(r >> 10) * term) / (mfd1 * pd1);
      c = 32'(raw << 10);
    end
    h = c / (32'(sh_div0[13:11]) + 1);
    p = h / (32'(sh_div0[7:6]) + 1);
  endtask

  task automatic access(input bit w, input int a, input logic [31:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    access(1'b0, a, '0);
  endtask

  task automatic bus_write(input int a, input logic [31:0] d, input bit exp_busy, input string tag);
    access(1'b1, a, d);
    chk(busy == exp_busy, tag, 32'(busy), 32'(exp_busy));
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic chk_freq(input string tag);
    logic [31:0] r, c, h, p;
    wait_idle();
    model(r, c, h, p);
    chk(ref_hz == r,  {tag, " R6 ref"},  ref_hz,  r);
    chk(core_hz == c, {tag, " R7 core"}, core_hz, c);
    chk(hs_hz == h,   {tag, " R8 hs"},   hs_hz,   h);
    chk(per_hz == p,  {tag, " R8 per"},  per_hz,  p);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected response", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    fails++;
    $display("FAIL R10 watchdog expired actual busy=%0d expected 0", busy);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] old_core;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R10 auto recalc after reset", 32'(busy), 32'h1);
    chk(core_hz == 32'h0, "R10 zero before first result", core_hz, 32'h0);
    chk(req_ready == 1'b0, "R5 ready low while busy", 32'(req_ready), 32'h0);
    chk_freq("R10 reset");
    chk(core_hz == 32'd155996160, "R7 reset core literal", core_hz, 32'd155996160);

    bus_read(0,  32'h074B0B7B, "R1 mode");
    bus_read(1,  32'hFF870B48, "R1 div0");
    bus_read(2,  32'h49FCFE7F, "R1 div1");
    bus_read(4,  32'h04001800, "R1 pll main");
    bus_read(6,  32'h04043001, "R1 pll serial");
    for (int g = 8; g <= 10; g++) bus_read(g, 32'hFFFFFFFF, "R1 gating");
    bus_read(23, 32'h80209828, "R1 pm");
    bus_read(18, 32'h00004040, "R4 const");
    bus_read(3,  32'h0, "R4 unmapped 3");
    bus_read(31, 32'h0, "R4 unmapped 31");

    // R2 mode masks; R9 trigger
    bus_write(0, 32'hFFFFFFFF, 1'b1, "R9 mode write busy");
    sh_mode = 32'h3F6FDFFF;
    bus_read(0, 32'h3F6FDFFF, "R2 mode all ones");
    chk_freq("R7 bypass MDS");
    bus_write(0, 32'h0, 1'b1, "R9 mode write busy");
    sh_mode = 32'h04000000;
    bus_read(0, 32'h04000000, "R2 forced bit");
    chk_freq("R7 bypass MPE clear");

    // R6 low reference through PLL, R10 hold during busy
    old_core = core_hz;
    bus_write(0, 32'h00000005, 1'b1, "R9 mode write busy");
    sh_mode = 32'h04000005;
    chk(core_hz == old_core, "R10 hold while busy", core_hz, old_core);
    chk(req_ready == 1'b0, "R5 back-pressure", 32'(req_ready), 32'h0);
    chk_freq("R6 low ref");

    // R3 divider0 mask, R8 dividers
    bus_write(1, 32'hFFFFFFFF, 1'b1, "R9 div0 write busy");
    sh_div0 = 32'hFF9F3FFF;
    bus_read(1, 32'hFF9F3FFF, "R3 div0 mask");
    chk_freq("R8 max dividers");

    // R3 PLL mask, R7 clamp and negative numerator
    bus_write(4, 32'hC00309FD, 1'b1, "R9 pll write busy");
    sh_pllm = 32'h800309FD;
    bus_read(4, 32'h800309FD, "R3 pll mask");
    chk_freq("R7 mfi clamp");
    bus_write(4, 32'h000017F8, 1'b1, "R9 pll write busy");
    sh_pllm = 32'h000017F8;
    chk_freq("R7 non-positive term");
    bus_write(1, 32'h00000848, 1'b1, "R9 div0 write busy");
    sh_div0 = 32'h00000848;
    bus_write(4, 32'h04001800, 1'b1, "R9 pll write busy");
    sh_pllm = 32'h04001800;
    chk_freq("R8 mixed dividers");

    bus_write(6, 32'hFFFFFFFF, 1'b1, "R9 serial pll write busy");
    bus_read(6, 32'hBFFF3FFF, "R3 serial pll mask");
    bus_write(2, 32'h12345678, 1'b1, "R9 div1 write busy");
    bus_read(2, 32'h12345678, "R3 div1 full");
    wait_idle();

    for (int g = 8; g <= 10; g++) begin
      bus_write(g, 32'hA5000000 + 32'(g), 1'b0, "R9 gating no recalc");
      bus_read(g, 32'hA5000000 + 32'(g), "R3 gating full");
    end

    bus_write(23, 32'h0, 1'b0, "R4 pm write no recalc");
    bus_read(23, 32'h80209828, "R4 pm ignores write");
    bus_write(18, 32'h0, 1'b0, "R4 const write no recalc");
    bus_read(18, 32'h00004040, "R4 const ignores write");
    bus_write(5, 32'hFFFFFFFF, 1'b0, "R4 unmapped write no recalc");
    bus_read(5, 32'h0, "R4 unmapped still zero");
    bus_read(0, sh_mode, "R4 mode untouched");
    chk_freq("R4 freqs untouched");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 responses drained", 32'(exp_q.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule